// File: doc/BRIEF.md
# Synchronous burst SRAM model

This block is a cycle-accurate behavioural model of a single-port synchronous SRAM with a shared bidirectional data bus, four 9-bit byte lanes and a small, parameterised depth. On each rising clock edge that is not stalled, the block decodes one command from the chip enable, write enable and advance/load inputs. The command is deselect, start a read burst, start a write burst, or continue the open burst at its next address. Write data and the lane mask follow the address by one edge. Read data reaches the bus two edges after its address, so reads and writes can alternate with no idle cycle between them.

The output enable acts on the bus drivers without the clock and cannot open them during the data phase of a write. An active-high stall input freezes the whole pipeline. A sleep input, synchronised over two edges, parks the block and keeps the memory contents. The order of addresses within a burst comes from a separate sequencer, which is interleaved by default and linear when a parameter selects it.

Top module: `sync_burst_sram`

## Requirements
- R1: A write command (ce_ni=0, we_ni=0, adv_i=0) accepted at edge E takes addr_i at E, and takes the write data from dq_io and the lane mask from bw_ni at the next unstalled edge E+1.
- R2: Lane i is bits dq_io[9i+8:9i]. It is written only when bw_ni[i]=0. A lane with bw_ni[i]=1 keeps its old contents.
- R3: In the cycle after a write command edge (the write data phase), the block does not drive dq_io, even with oe_ni low and a read result pending.
- R4: A read command (ce_ni=0, we_ni=1, adv_i=0) accepted at edge E drives the addressed word on dq_io after unstalled edge E+2 while oe_ni is low, and holds it until the next edge.
- R5: oe_ni gates the drivers without the clock: the bus is released while oe_ni=1 and opens as soon as oe_ni falls. A read with oe_ni=1 is a dummy read, which still advances the pipeline.
- R6: With adv_i=1 and a burst open, ce_ni and we_ni are ignored and the burst's own operation repeats at the next address. With BURST_LINEAR=0, the low two address bits are the start bits XOR the access count (1, 2, 3, then wrap). With BURST_LINEAR=1 they are the start bits plus the count, modulo 4.
- R7: A deselect (ce_ni=1, adv_i=0) starts no access and closes the burst. adv_i=1 with no open burst is a no-op that writes nothing.
- R8: With cke_ni=1, no command, write data or mask is taken, and the pipeline state and the bus value are held.
- R9: During and after reset the block is deselected and dq_io is released whatever oe_ni is.
- R10: sleep_i takes effect after two edges and releases after two edges. Commands at edges while the block is asleep are ignored, pending accesses are dropped, the bus is released, and the memory keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low; high inserts a wait state |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| adv_i | input | 1 | High: continue burst; low: load a new command |
| bw_ni | input | LANES | Per-lane write enable, active low, taken in the data phase |
| addr_i | input | ADDR_W | Word address |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep request, asynchronous, active high |
| dq_io | inout | LANES*LANE_W | Shared data bus, released when not driven |

## Verification
The bench builds the block with the default parameters: 64 words, four 9-bit lanes and the interleaved burst order. The small depth lets a single table walk through bursts, merged lane writes and no-op continuations while every address the bench uses stays known. The interleaved order exercises the wrap from the start address back through lower addresses in one four-access burst. The linear order is not built by the bench.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/sbs_cmd_decode.sv
module sbs_cmd_decode
  import sbs_pkg::*;
(
  input  logic ce_ni,
  input  logic we_ni,
  input  logic adv_i,
  input  logic burst_act_i,
  input  op_e  burst_op_i,
  output op_e  op_o,
  output logic load_o,
  output logic step_o,
  output logic close_o
);
  always_comb begin
    op_o    = OP_NONE;
    load_o  = 1'b0;
    step_o  = 1'b0;
    close_o = 1'b0;
    if (adv_i) begin
      // continuation ignores ce/we; no-op without an open burst
      if (burst_act_i) begin
        op_o   = burst_op_i;
        step_o = 1'b1;
      end
    end else if (ce_ni) begin
      close_o = 1'b1;
    end else begin
      load_o = 1'b1;
      op_o   = we_ni ? OP_RD : OP_WR;
    end
  end
endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 2,
  parameter bit LINEAR = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              step_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] next_o
);
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nx, low;

  assign cnt_nx = cnt_q + 1'b1;

  if (LINEAR) begin : g_lin
    assign low = base_q[CNT_W-1:0] + cnt_nx;
  end else begin : g_ilv
    assign low = base_q[CNT_W-1:0] ^ cnt_nx;
  end

  assign next_o = {base_q[ADDR_W-1:CNT_W], low};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
      end else if (step_i) begin
        cnt_q <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/sbs_sleep_sync.sv
module sbs_sleep_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic asleep_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], req_i};
  end

  assign asleep_o = sh_q[STAGES-1];
endmodule

// File: rtl/sbs_lane_mem.sv
module sbs_lane_mem #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    we_i,
  input  logic [LANES-1:0]        lane_en_i,
  input  logic [ADDR_W-1:0]       waddr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0]       raddr_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] arr [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && lane_en_i[g]) arr[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = arr[raddr_i];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int LANES        = 4,
  parameter int LANE_W       = 9,
  parameter int BURST_CNT_W  = 2,
  parameter int SLEEP_STAGES = 2,
  parameter bit BURST_LINEAR = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    cke_ni,
  input  logic                    ce_ni,
  input  logic                    we_ni,
  input  logic                    adv_i,
  input  logic [LANES-1:0]        bw_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  inout  wire  [LANES*LANE_W-1:0] dq_io
);
  localparam int DATA_W = LANES * LANE_W;

  logic              asleep, run;
  logic              burst_act_q;
  op_e               burst_op_q;
  op_e               dec_op;
  logic              dec_load, dec_step, dec_close;
  logic [ADDR_W-1:0] seq_next, acc_addr;
  op_e               s1_op_q;
  logic [ADDR_W-1:0] s1_addr_q, s2_addr_q;
  logic              s2_rd_q, drv_q;
  logic [DATA_W-1:0] dout_q, mem_rdata;
  logic              wr_phase, s1_busy, dq_en;

  sbs_sleep_sync #(.STAGES(SLEEP_STAGES)) u_sleep (
    .clk_i, .rst_ni, .req_i(sleep_i), .asleep_o(asleep)
  );

  assign run = !cke_ni && !asleep;

  sbs_cmd_decode u_dec (
    .ce_ni, .we_ni, .adv_i,
    .burst_act_i(burst_act_q), .burst_op_i(burst_op_q),
    .op_o(dec_op), .load_o(dec_load), .step_o(dec_step), .close_o(dec_close)
  );

  sbs_burst_seq #(.ADDR_W(ADDR_W), .CNT_W(BURST_CNT_W), .LINEAR(BURST_LINEAR)) u_seq (
    .clk_i, .rst_ni, .en_i(run), .load_i(dec_load), .step_i(dec_step),
    .addr_i, .next_o(seq_next)
  );

  assign acc_addr = dec_load ? addr_i : seq_next;
  assign wr_phase = (s1_op_q == OP_WR);
  assign s1_busy  = (s1_op_q != OP_NONE);

  sbs_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk_i,
    .we_i(run && wr_phase),
    .lane_en_i(~bw_ni),
    .waddr_i(s1_addr_q),
    .wdata_i(dq_io),
    .raddr_i(s2_addr_q),
    .rdata_o(mem_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_act_q <= 1'b0;
      burst_op_q  <= OP_NONE;
      s1_op_q     <= OP_NONE;
      s1_addr_q   <= '0;
      s2_rd_q     <= 1'b0;
      s2_addr_q   <= '0;
      drv_q       <= 1'b0;
      dout_q      <= '0;
    end else if (asleep) begin
      // pending accesses are dropped on sleep
      burst_act_q <= 1'b0;
      s1_op_q     <= OP_NONE;
      s2_rd_q     <= 1'b0;
      drv_q       <= 1'b0;
    end else if (!cke_ni) begin
      if (dec_load) begin
        burst_act_q <= 1'b1;
        burst_op_q  <= dec_op;
      end else if (dec_close) begin
        burst_act_q <= 1'b0;
      end
      s1_op_q   <= dec_op;
      s1_addr_q <= acc_addr;
      s2_rd_q   <= (s1_op_q == OP_RD);
      s2_addr_q <= s1_addr_q;
      drv_q     <= s2_rd_q;
      dout_q    <= mem_rdata;
    end
  end

  assign dq_en = drv_q && !oe_ni && !wr_phase;
  assign dq_io = dq_en ? dout_q : 'z;
endmodule

// File: rtl/sync_burst_sram_chk.sv
module sync_burst_sram_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cke_ni,
  input logic ce_ni,
  input logic we_ni,
  input logic adv_i,
  input logic oe_ni,
  input logic asleep_i,
  input logic burst_act_i,
  input logic rd_valid_i,
  input logic s1_busy_i,
  input logic dq_en_i
);
  assert_wr_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !asleep_i && !adv_i && !ce_ni && !we_ni) |=> !dq_en_i);

  assert_oe_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !dq_en_i);

  assert_desel_close_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !asleep_i && !adv_i && ce_ni) |=> (!s1_busy_i && !burst_act_i));

  assert_adv_nop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !asleep_i && adv_i && !burst_act_i) |=> !s1_busy_i);

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_ni && !asleep_i) |=>
      ($stable(rd_valid_i) && $stable(s1_busy_i) && $stable(burst_act_i)));

  assert_sleep_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    asleep_i |=> (!rd_valid_i && !s1_busy_i && !burst_act_i));
endmodule

bind sync_burst_sram sync_burst_sram_chk u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .cke_ni(cke_ni),
  .ce_ni(ce_ni),
  .we_ni(we_ni),
  .adv_i(adv_i),
  .oe_ni(oe_ni),
  .asleep_i(asleep),
  .burst_act_i(burst_act_q),
  .rd_valid_i(drv_q),
  .s1_busy_i(s1_busy),
  .dq_en_i(dq_en)
);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int DW = 36;
  localparam logic [DW-1:0] ZV = {DW{1'b1}};  // released bus reads high via pullups
  localparam logic [DW-1:0] DA = {9'h101, 9'h102, 9'h103, 9'h104};
  localparam logic [DW-1:0] DB = {9'h0A1, 9'h0A2, 9'h0A3, 9'h0A4};
  localparam logic [DW-1:0] DC = {9'h055, 9'h066, 9'h077, 9'h088};
  localparam logic [DW-1:0] DD = {9'h1C0, 9'h1C1, 9'h1C2, 9'h1C3};
  localparam logic [DW-1:0] NW = {9'h1F0, 9'h1F1, 9'h1F2, 9'h1F3};
  localparam logic [DW-1:0] MG = {9'h101, 9'h1F1, 9'h103, 9'h1F3};

  typedef struct packed {
    logic          ce_n, we_n, adv, oe_n;
    logic [3:0]    bw_n;
    logic [5:0]    addr;
    logic          drv;
    logic [DW-1:0] wd;
    logic [1:0]    chk;   // 0 none, 1 released, 2 value
    logic [3:0]    req;
    logic [DW-1:0] exp;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd8, 1'b0,'0,2'd0,4'd1,'0},   // R1 write burst at 8
    '{1'b1,1'b1,1'b1,1'b0,4'h0,6'd0, 1'b1,DA,2'd0,4'd6,'0},   // R6 -> 9, DA into 8
    '{1'b1,1'b1,1'b1,1'b0,4'h0,6'd0, 1'b1,DB,2'd0,4'd6,'0},   // -> 10, DB into 9
    '{1'b1,1'b1,1'b1,1'b0,4'h0,6'd0, 1'b1,DC,2'd0,4'd6,'0},   // -> 11, DC into 10
    '{1'b1,1'b1,1'b0,1'b0,4'h0,6'd0, 1'b1,DD,2'd0,4'd7,'0},   // deselect, DD into 11
    '{1'b0,1'b1,1'b0,1'b0,4'hF,6'd10,1'b0,'0,2'd0,4'd4,'0},   // R4 read burst at 10
    '{1'b1,1'b1,1'b1,1'b0,4'hF,6'd0, 1'b0,'0,2'd0,4'd6,'0},   // -> 11
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd0, 1'b0,'0,2'd2,4'd4,DC},   // -> 8, out addr 10
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd0, 1'b0,'0,2'd2,4'd6,DD},   // -> 9, out addr 11
    '{1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, 1'b0,'0,2'd2,4'd6,DA},   // out addr 8 (wrap)
    '{1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, 1'b0,'0,2'd2,4'd6,DB},   // out addr 9
    '{1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, 1'b0,'0,2'd1,4'd7,'0},   // R7 idle, released
    '{1'b0,1'b0,1'b0,1'b0,4'hF,6'd8, 1'b0,'0,2'd0,4'd2,'0},   // R2 write 8
    '{1'b1,1'b1,1'b0,1'b0,4'hA,6'd0, 1'b1,NW,2'd0,4'd2,'0},   // lanes 0,2 only
    '{1'b0,1'b1,1'b0,1'b0,4'hF,6'd8, 1'b0,'0,2'd0,4'd2,'0},
    '{1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, 1'b0,'0,2'd0,4'd2,'0},
    '{1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, 1'b0,'0,2'd2,4'd2,MG},   // R2 merged
    '{1'b0,1'b1,1'b0,1'b1,4'hF,6'd9, 1'b0,'0,2'd0,4'd5,'0},   // R5 dummy read
    '{1'b1,1'b1,1'b0,1'b1,4'hF,6'd0, 1'b0,'0,2'd0,4'd5,'0},
    '{1'b1,1'b1,1'b0,1'b1,4'hF,6'd0, 1'b0,'0,2'd1,4'd5,'0},
    '{1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, 1'b0,'0,2'd0,4'd7,'0},
    '{1'b0,1'b0,1'b1,1'b0,4'hF,6'd0, 1'b0,'0,2'd0,4'd7,'0},   // R7 adv, no burst
    '{1'b1,1'b1,1'b0,1'b0,4'h0,6'd0, 1'b1,'0,2'd0,4'd7,'0},   // junk must not land
    '{1'b0,1'b1,1'b0,1'b0,4'hF,6'd8, 1'b0,'0,2'd0,4'd7,'0},
    '{1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, 1'b0,'0,2'd0,4'd7,'0},
    '{1'b1,1'b1,1'b0,1'b0,4'hF,6'd0, 1'b0,'0,2'd2,4'd7,MG}    // R7 addr 8 intact
  };

  logic clk = 1'b0, rst_n = 1'b1;
  logic cke_n = 1'b0, ce_n = 1'b1, we_n = 1'b1, adv = 1'b0, oe_n = 1'b0, slp = 1'b0;
  logic [3:0] bw_n = 4'hF;
  logic [5:0] addr = '0;
  logic tb_drv = 1'b0;
  logic [DW-1:0] tb_wd = '0;
  wire  [DW-1:0] dq;
  int total = 0, bad = 0;

  assign dq = tb_drv ? tb_wd : 'z;
  for (genvar i = 0; i < DW; i++) begin : g_pu
    pullup (dq[i]);
  end

  always #2 clk = ~clk;

  sync_burst_sram uut (
    .clk_i(clk), .rst_ni(rst_n), .cke_ni(cke_n), .ce_ni(ce_n), .we_ni(we_n),
    .adv_i(adv), .bw_ni(bw_n), .addr_i(addr), .oe_ni(oe_n), .sleep_i(slp),
    .dq_io(dq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] exp);
    total++;
    if (dq !== exp) begin
      bad++;
      $display("FAIL %s: dq=%h expected=%h", tag, dq, exp);
    end
  endtask

  task automatic cyc(input logic c, input logic w, input logic a, input logic o,
                     input logic [3:0] b, input logic [5:0] ad,
                     input logic d, input logic [DW-1:0] wd);
    ce_n = c; we_n = w; adv = a; oe_n = o; bw_n = b; addr = ad;
    tb_drv = d; tb_wd = wd;
    @(posedge clk);
    #1 tb_drv = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, 1'b0, oe_n, 4'hF, 6'd0, 1'b0, '0);
  endtask

  task automatic rd(input logic [5:0] ad);
    cyc(1'b0, 1'b1, 1'b0, oe_n, 4'hF, ad, 1'b0, '0);
  endtask

  task automatic wr(input logic [5:0] ad);
    cyc(1'b0, 1'b0, 1'b0, oe_n, 4'hF, ad, 1'b0, '0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk("R9 in reset", ZV);
    @(negedge clk);
    rst_n = 1'b1;
    idle();
    idle();
    chk("R9 after reset", ZV);

    for (int k = 0; k < NV; k++) begin
      cyc(VEC[k].ce_n, VEC[k].we_n, VEC[k].adv, VEC[k].oe_n,
          VEC[k].bw_n, VEC[k].addr, VEC[k].drv, VEC[k].wd);
      if (VEC[k].chk == 2'd1) chk($sformatf("R%0d vec %0d", VEC[k].req, k), ZV);
      else if (VEC[k].chk == 2'd2) chk($sformatf("R%0d vec %0d", VEC[k].req, k), VEC[k].exp);
    end

    // R8 stall freezes pipeline and bus
    rd(6'd10);
    cke_n = 1'b1;
    rd(6'd11); rd(6'd11); rd(6'd11);
    chk("R8 stalled read", ZV);
    cke_n = 1'b0;
    idle();
    chk("R8 resume 1", ZV);
    idle();
    chk("R8 resume 2", DC);
    cke_n = 1'b1;
    idle(); idle();
    chk("R8 output held", DC);
    cke_n = 1'b0;
    idle();
    chk("R8 after stall", ZV);

    // R3 write data phase masks a pending read result
    rd(6'd8);
    wr(6'd20);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 4'h0, 6'd21, 1'b1, DA);
    chk("R3 bus released in data phase", ZV);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 6'd0, 1'b1, DB);
    rd(6'd20); idle(); idle();
    chk("R1 readback 20", DA);
    rd(6'd21); idle(); idle();
    chk("R1 readback 21", DB);

    // R5 asynchronous output enable
    oe_n = 1'b1;
    rd(6'd9); idle(); idle();
    chk("R5 oe high", ZV);
    oe_n = 1'b0;
    #1 chk("R5 oe falls without clock", DB);
    oe_n = 1'b1;
    #1 chk("R5 oe rises without clock", ZV);
    oe_n = 1'b0;
    idle();

    // R10 sleep entry and exit
    wr(6'd30);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 4'h0, 6'd0, 1'b1, DD);
    slp = 1'b1;
    idle(); idle();
    rd(6'd30); idle(); idle();
    chk("R10 read ignored asleep", ZV);
    slp = 1'b0;
    idle();
    rd(6'd30);
    idle(); idle();
    chk("R10 read ignored during exit", ZV);
    rd(6'd30); idle(); idle();
    chk("R10 contents kept", DD);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule